// File: doc/BRIEF.md
# Serial One-Time-Programmable Memory Command Front End

This block is the serial slave side of a one-time-programmable byte store. A host selects it by pulling chip select low and then clocks 8-bit commands into the serial data input, most significant bit first. Three commands are understood. The first streams a constant status byte for as long as clocks continue. The second streams a two-byte identification pair. The third takes a 24-bit byte address and then any number of data bytes, which are burned into consecutive locations.

All serial pins are sampled with the local system clock through synchronizer stages, and their edges are detected in that clock domain. Input data is captured on rising serial-clock edges and output data moves on falling edges. This holds whether the bus idles with the serial clock low or high; that idle level is recorded at every chip-select fall. A hold input can freeze a transfer part-way through. The internal array has a parameterized depth. A write can only clear bits, and a read port lets the surrounding logic see the stored values.

Top module: `otp_spi_slave`

## Requirements
- R1: After reset `so_oe` is low, `pg_we` is low and every array location reads 8'hFF through `rd_idx`/`rd_data`.
- R2: Commands are accepted only after a high-to-low chip-select transition has been seen since reset. Clocking with chip select held low from reset produces no output enable and no write.
- R3: Command bytes whose value ANDed with 8'hF7 equals 8'h05 (bit 3 is ignored) make the block return 8'h8C, MSB first. The first bit appears after the falling serial-clock edge that follows the eighth command bit, and the byte repeats with no gap while clocking continues.
- R4: Command bytes whose value ANDed with 8'hF7 equals 8'h15 return 8'h1C and then 8'h83, MSB first, and the pair repeats while clocking continues.
- R5: Command 8'h99 is followed by a 24-bit address, MSB first, and then data bytes, MSB first. Each complete data byte gives exactly one single-cycle `pg_we` pulse, with `pg_addr` set to the target address and `pg_data` set to the byte.
- R6: The target address increments after each byte and wraps from 24'hFFFFFF to 0. The array location written is the address modulo DEPTH.
- R7: A data byte with fewer than 8 bits when chip select rises is discarded, and no write occurs.
- R8: A write stores the AND of the old contents and the new data, so a bit can only go from 1 to 0.
- R9: Any other command byte leaves `so_oe` low, and all further bits are ignored until chip select rises. A following 8'h99 pattern does not write.
- R10: `hold_n` is sampled only while the serial clock is low. While the block is held, `so_oe` is low and serial-clock edges and serial data are ignored. The transfer resumes exactly where it stopped.
- R11: At each chip-select fall `idle_hi` records the serial-clock level, 1 for an idle-high bus. Both idle levels give identical command behaviour.
- R12: `so_oe` is low while chip select is high and while a command byte is being shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low transfer pause |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; low means high-impedance |
| idle_hi | output | 1 | Serial-clock idle level captured at the last chip-select fall |
| pg_we | output | 1 | One-cycle write strobe per completed data byte |
| pg_addr | output | ADDR_W | Full address of the byte being written |
| pg_data | output | 8 | Data byte being written |
| rd_idx | input | IDX_W | Array location to observe |
| rd_data | output | 8 | Stored contents of `rd_idx` |

## Verification
Read commands are tried with both values of the ignored opcode bit and with both idle clock levels. This separates a full-byte opcode compare and a mode-dependent start from the correct decode. Program bursts start just below the DEPTH boundary and at the top of the 24-bit space, which separates the index wrap from the full-address wrap. Rewrites of one location show whether the array ANDs or overwrites. Partial bytes, an unknown opcode followed by a program pattern, and hold pauses with the clock and data toggling show whether stray bits leak into the state.

// File: rtl/otp_spi_pkg.sv
package otp_spi_pkg;
   typedef enum logic [2:0] {
      PH_OPC,
      PH_STAT,
      PH_IDENT,
      PH_ADDR,
      PH_DATA,
      PH_SKIP
   } phase_t;

   localparam logic [7:0] OPC_MASK  = 8'hF7;
   localparam logic [7:0] OPC_STAT  = 8'h05;
   localparam logic [7:0] OPC_IDENT = 8'h15;
   localparam logic [7:0] OPC_PROG  = 8'h99;
   localparam logic [7:0] STAT_BYTE = 8'h8C;
   localparam logic [7:0] MFR_BYTE  = 8'h1C;
   localparam logic [7:0] DEV_BYTE  = 8'h83;
endpackage

// File: rtl/otp_spi_sync.sv
module otp_spi_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic q_d
);
   logic [STAGES:0] pipe;

   assign pipe[0] = d;

   generate
      for (genvar g = 1; g <= STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= RST_VAL;
            else        pipe[g] <= pipe[g-1];
         end
      end
   endgenerate

   assign q = pipe[STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_d <= RST_VAL;
      else        q_d <= q;
   end
endmodule

// File: rtl/otp_spi_array.sv
module otp_spi_array #(
   parameter int DEPTH = 256,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [7:0]       wdata,
   input  logic [IDX_W-1:0] ridx,
   output logic [7:0]       rdata
);
   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
      end else if (we) begin
         cells[widx] <= cells[widx] & wdata;
      end
   end

   assign rdata = cells[ridx];
endmodule

// File: rtl/otp_spi_cmd.sv
module otp_spi_cmd
   import otp_spi_pkg::*;
#(
   parameter int ADDR_W = 24,
   localparam int CNT_W = $clog2(ADDR_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_high,
   input  logic              cs_fall,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              si_s,
   input  logic              held,
   output logic              armed,
   output logic              so,
   output logic              so_oe,
   output logic              pg_we,
   output logic [ADDR_W-1:0] pg_addr,
   output logic [7:0]        pg_data
);
   phase_t            phase;
   logic [CNT_W-1:0]  cnt;
   logic [7:0]        sh8;
   logic [ADDR_W-1:0] addr;
   logic              started;
   logic [2:0]        oidx;
   logic              second;
   logic [7:0]        obyte;
   logic [7:0]        sh_nx;

   assign sh_nx = {sh8[6:0], si_s};
   assign obyte = (phase == PH_STAT) ? STAT_BYTE : (second ? DEV_BYTE : MFR_BYTE);
   assign so    = obyte[oidx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_OPC;
         cnt     <= '0;
         sh8     <= '0;
         addr    <= '0;
         armed   <= 1'b0;
         started <= 1'b0;
         oidx    <= 3'd7;
         second  <= 1'b0;
         so_oe   <= 1'b0;
         pg_we   <= 1'b0;
         pg_addr <= '0;
         pg_data <= '0;
      end else begin
         pg_we <= 1'b0;
         if (cs_high) begin
            phase   <= PH_OPC;
            cnt     <= '0;
            armed   <= 1'b0;
            started <= 1'b0;
            second  <= 1'b0;
            so_oe   <= 1'b0;
         end else begin
            if (cs_fall) armed <= 1'b1;
            so_oe <= started & ~held;
            if (armed && !held && sck_rise) begin
               unique case (phase)
                  PH_OPC: begin
                     sh8 <= sh_nx;
                     if (cnt == CNT_W'(7)) begin
                        cnt <= '0;
                        if ((sh_nx & OPC_MASK) == OPC_STAT)       phase <= PH_STAT;
                        else if ((sh_nx & OPC_MASK) == OPC_IDENT) phase <= PH_IDENT;
                        else if (sh_nx == OPC_PROG)               phase <= PH_ADDR;
                        else                                      phase <= PH_SKIP;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  PH_ADDR: begin
                     addr <= {addr[ADDR_W-2:0], si_s};
                     if (cnt == CNT_W'(ADDR_W-1)) begin
                        cnt   <= '0;
                        phase <= PH_DATA;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  PH_DATA: begin
                     sh8 <= sh_nx;
                     if (cnt == CNT_W'(7)) begin
                        cnt     <= '0;
                        pg_we   <= 1'b1;
                        pg_addr <= addr;
                        pg_data <= sh_nx;
                        addr    <= addr + 1'b1;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
            if (armed && !held && sck_fall &&
                (phase == PH_STAT || phase == PH_IDENT)) begin
               if (!started) begin
                  started <= 1'b1;
                  oidx    <= 3'd7;
                  second  <= 1'b0;
               end else if (oidx == 3'd0) begin
                  oidx   <= 3'd7;
                  second <= ~second;
               end else begin
                  oidx <= oidx - 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/otp_spi_slave.sv
module otp_spi_slave #(
   parameter int ADDR_W      = 24,
   parameter int DEPTH       = 256,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              si,
   input  logic              hold_n,
   output logic              so,
   output logic              so_oe,
   output logic              idle_hi,
   output logic              pg_we,
   output logic [ADDR_W-1:0] pg_addr,
   output logic [7:0]        pg_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [7:0]        rd_data
);
   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (ADDR_W < IDX_W || ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must cover the array index and be at least 8");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic s_csn, p_csn, s_sck, p_sck, s_si, p_si, s_hold, p_hold;
   logic cs_fall, sck_rise, sck_fall, held, cmd_armed;

   otp_spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d(cs_n), .q(s_csn), .q_d(p_csn));
   otp_spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
      .clk(clk), .rst_n(rst_n), .d(sck), .q(s_sck), .q_d(p_sck));
   otp_spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_si (
      .clk(clk), .rst_n(rst_n), .d(si), .q(s_si), .q_d(p_si));
   otp_spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_hold (
      .clk(clk), .rst_n(rst_n), .d(hold_n), .q(s_hold), .q_d(p_hold));

   assign cs_fall  = p_csn & ~s_csn;
   assign sck_rise = s_sck & ~p_sck;
   assign sck_fall = ~s_sck & p_sck;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held    <= 1'b0;
         idle_hi <= 1'b0;
      end else begin
         if (s_csn)       held <= 1'b0;
         else if (!s_sck) held <= ~s_hold;
         if (cs_fall) idle_hi <= s_sck;
      end
   end

   otp_spi_cmd #(.ADDR_W(ADDR_W)) u_cmd (
      .clk(clk), .rst_n(rst_n), .cs_high(s_csn), .cs_fall(cs_fall),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(s_si), .held(held),
      .armed(cmd_armed), .so(so), .so_oe(so_oe), .pg_we(pg_we),
      .pg_addr(pg_addr), .pg_data(pg_data));

   otp_spi_array #(.DEPTH(DEPTH)) u_array (
      .clk(clk), .rst_n(rst_n), .we(pg_we), .widx(pg_addr[IDX_W-1:0]),
      .wdata(pg_data), .ridx(rd_idx), .rdata(rd_data));

   logic unused_ok;
   assign unused_ok = &{1'b0, p_si, p_hold};
endmodule

// File: rtl/otp_spi_slave_chk.sv
module otp_spi_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic s_csn,
   input logic cs_fall,
   input logic held,
   input logic cmd_armed,
   input logic so_oe,
   input logic pg_we,
   input logic idle_hi
);
   assert_oe_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
      s_csn |=> !so_oe);

   assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pg_we |=> !pg_we);

   assert_unarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_armed |=> !pg_we);

   assert_hold_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
      held |-> !pg_we);

   assert_hold_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (held && $past(held)) |-> !so_oe);

   assert_mode_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cs_fall) |-> $stable(idle_hi));
endmodule

bind otp_spi_slave otp_spi_slave_chk u_chk (
   .clk(clk), .rst_n(rst_n), .s_csn(s_csn), .cs_fall(cs_fall), .held(held),
   .cmd_armed(cmd_armed), .so_oe(so_oe), .pg_we(pg_we), .idle_hi(idle_hi));

// File: tb/otp_spi_slave_test.sv
module otp_spi_slave_test;
   localparam int HP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b0;
   logic        sck = 1'b0;
   logic        si = 1'b0;
   logic        hold_n = 1'b1;
   logic        so, so_oe, idle_hi, pg_we;
   logic [23:0] pg_addr;
   logic [7:0]  pg_data;
   logic [7:0]  rd_idx = 8'd0;
   logic [7:0]  rd_data;

   int total = 0;
   int bad = 0;

   logic [7:0]  exp_rd[$];
   string       exp_rd_tag[$];
   logic [7:0]  got_rd[$];
   logic [31:0] exp_wr[$];
   string       exp_wr_tag[$];

   always #4 clk = ~clk;

   otp_spi_slave uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .hold_n(hold_n), .so(so), .so_oe(so_oe), .idle_hi(idle_hi),
      .pg_we(pg_we), .pg_addr(pg_addr), .pg_data(pg_data),
      .rd_idx(rd_idx), .rd_data(rd_data));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bitx(input logic b, output logic o, output logic oe);
      sck = 1'b0;
      si  = b;
      tick(HP);
      o  = so;
      oe = so_oe;
      sck = 1'b1;
      tick(HP);
   endtask

   task automatic xbyte(input logic [7:0] b, output logic [7:0] o, output logic anyoe);
      logic ob, oe;
      anyoe = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         bitx(b[i], ob, oe);
         o[i] = ob;
         anyoe = anyoe | oe;
      end
   endtask

   task automatic cs_start(input logic m3);
      sck = m3;
      tick(HP);
      cs_n = 1'b0;
      tick(HP);
   endtask

   task automatic cs_stop(input logic m3);
      if (!m3) begin
         sck = 1'b0;
         tick(HP);
      end
      cs_n = 1'b1;
      tick(HP);
   endtask

   task automatic read_cmd(input logic m3, input logic [7:0] opc,
                           input logic [7:0] e0, input logic [7:0] e1,
                           input logic [7:0] e2, input int nbytes, input string tag);
      logic [7:0] o;
      logic       oe;
      cs_start(m3);
      check({tag, " R11 idle level"}, {31'd0, idle_hi}, {31'd0, m3});
      xbyte(opc, o, oe);
      check("R12 no enable during command", {31'd0, oe}, 32'd0);
      for (int k = 0; k < nbytes; k++) begin
         exp_rd.push_back(k == 0 ? e0 : (k == 1 ? e1 : e2));
         exp_rd_tag.push_back(tag);
         xbyte(8'h00, o, oe);
         got_rd.push_back(o);
      end
      cs_stop(m3);
      check("R12 disabled after deselect", {31'd0, so_oe}, 32'd0);
   endtask

   task automatic prog_cmd(input logic m3, input logic [23:0] a,
                           input logic [7:0] d0, input logic [7:0] d1,
                           input logic [7:0] d2, input int nbytes, input string tag);
      logic [7:0] o;
      logic       oe;
      logic [23:0] ea;
      ea = a;
      cs_start(m3);
      xbyte(8'h99, o, oe);
      xbyte(a[23:16], o, oe);
      xbyte(a[15:8], o, oe);
      xbyte(a[7:0], o, oe);
      for (int k = 0; k < nbytes; k++) begin
         logic [7:0] d;
         d = (k == 0) ? d0 : ((k == 1) ? d1 : d2);
         exp_wr.push_back({ea, d});
         exp_wr_tag.push_back(tag);
         ea = ea + 24'd1;
         xbyte(d, o, oe);
      end
      cs_stop(m3);
   endtask

   always @(negedge clk) begin
      if (got_rd.size() > 0 && exp_rd.size() > 0) begin
         logic [7:0] g, e;
         string t;
         g = got_rd.pop_front();
         e = exp_rd.pop_front();
         t = exp_rd_tag.pop_front();
         check({t, " read byte"}, {24'd0, g}, {24'd0, e});
      end
      if (pg_we === 1'b1) begin
         if (exp_wr.size() == 0) begin
            check("R2/R7/R9 unexpected write", {pg_addr, pg_data}, 32'hFFFFFFFF);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_wr.pop_front();
            t = exp_wr_tag.pop_front();
            check({t, " write strobe"}, {pg_addr, pg_data}, e);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] o;
      logic       oe, anyoe, ob;
      logic [7:0] hb;
      tick(5);
      rst_n = 1'b1;
      tick(4);
      // R1: reset state
      check("R1 so_oe after reset", {31'd0, so_oe}, 32'd0);
      check("R1 pg_we after reset", {31'd0, pg_we}, 32'd0);
      rd_idx = 8'd0;   tick(1); check("R1 cell 0", {24'd0, rd_data}, 32'hFF);
      rd_idx = 8'd255; tick(1); check("R1 cell 255", {24'd0, rd_data}, 32'hFF);

      // R2: chip select low since reset, no fall seen
      anyoe = 1'b0;
      xbyte(8'h99, o, oe); anyoe |= oe;
      xbyte(8'h00, o, oe); anyoe |= oe;
      xbyte(8'h00, o, oe); anyoe |= oe;
      xbyte(8'h00, o, oe); anyoe |= oe;
      xbyte(8'h00, o, oe); anyoe |= oe;
      check("R2 no enable before chip-select fall", {31'd0, anyoe}, 32'd0);
      rd_idx = 8'd0; tick(1);
      check("R2 cell 0 untouched", {24'd0, rd_data}, 32'hFF);
      sck = 1'b0;
      cs_n = 1'b1;
      tick(HP);

      // R3 and R4 in both idle levels, with both values of the ignored bit
      read_cmd(1'b0, 8'h05, 8'h8C, 8'h8C, 8'h8C, 3, "R3");
      read_cmd(1'b1, 8'h0D, 8'h8C, 8'h8C, 8'h8C, 2, "R3");
      read_cmd(1'b0, 8'h15, 8'h1C, 8'h83, 8'h1C, 3, "R4");
      read_cmd(1'b1, 8'h1D, 8'h1C, 8'h83, 8'h1C, 2, "R4");

      // R5 and R8: single byte, then rewrite the same location
      prog_cmd(1'b0, 24'h000005, 8'hA5, 8'h00, 8'h00, 1, "R5");
      rd_idx = 8'd5; tick(1);
      check("R5 stored byte", {24'd0, rd_data}, 32'hA5);
      prog_cmd(1'b1, 24'h000005, 8'h3C, 8'h00, 8'h00, 1, "R8");
      tick(1);
      check("R8 bits only cleared", {24'd0, rd_data}, 32'h24);

      // R6: burst across the array boundary, then across the 24-bit top
      prog_cmd(1'b1, 24'h0000FE, 8'h11, 8'h22, 8'h33, 3, "R6");
      rd_idx = 8'd0;   tick(1); check("R6 index wrap cell 0", {24'd0, rd_data}, 32'h33);
      rd_idx = 8'd255; tick(1); check("R6 cell 255", {24'd0, rd_data}, 32'h22);
      prog_cmd(1'b0, 24'hFFFFFF, 8'h7E, 8'h81, 8'h00, 2, "R6");
      rd_idx = 8'd255; tick(1); check("R6 R8 cell 255 after wrap", {24'd0, rd_data}, 32'h22);
      rd_idx = 8'd0;   tick(1); check("R6 R8 cell 0 after wrap", {24'd0, rd_data}, 32'h01);

      // R7: partial byte discarded
      cs_start(1'b0);
      xbyte(8'h99, o, oe);
      xbyte(8'h00, o, oe);
      xbyte(8'h00, o, oe);
      xbyte(8'h10, o, oe);
      for (int i = 0; i < 5; i++) bitx(1'b0, ob, oe);
      cs_stop(1'b0);
      rd_idx = 8'd16; tick(1);
      check("R7 partial byte dropped", {24'd0, rd_data}, 32'hFF);

      // R9: unknown opcode, followed by a program pattern
      cs_start(1'b0);
      anyoe = 1'b0;
      xbyte(8'h03, o, oe); anyoe |= oe;
      xbyte(8'h99, o, oe); anyoe |= oe;
      xbyte(8'h00, o, oe); anyoe |= oe;
      xbyte(8'h00, o, oe); anyoe |= oe;
      xbyte(8'h10, o, oe); anyoe |= oe;
      xbyte(8'h00, o, oe); anyoe |= oe;
      xbyte(8'h00, o, oe); anyoe |= oe;
      check("R9 no enable after unknown opcode", {31'd0, anyoe}, 32'd0);
      cs_stop(1'b0);
      tick(1);
      check("R9 cell 16 untouched", {24'd0, rd_data}, 32'hFF);

      // R10: pause in the middle of a status byte
      cs_start(1'b0);
      xbyte(8'h05, o, oe);
      hb = 8'h00;
      for (int i = 7; i >= 4; i--) begin bitx(1'b0, ob, oe); hb[i] = ob; end
      sck = 1'b0; tick(HP);
      hold_n = 1'b0; tick(HP);
      check("R10 output off while held", {31'd0, so_oe}, 32'd0);
      for (int i = 0; i < 3; i++) begin
         si = i[0]; sck = 1'b1; tick(HP);
         sck = 1'b0; tick(HP);
      end
      hold_n = 1'b1; tick(HP);
      for (int i = 3; i >= 0; i--) begin bitx(1'b0, ob, oe); hb[i] = ob; end
      exp_rd.push_back(8'h8C); exp_rd_tag.push_back("R10"); got_rd.push_back(hb);
      exp_rd.push_back(8'h8C); exp_rd_tag.push_back("R10");
      xbyte(8'h00, o, oe);
      got_rd.push_back(o);
      cs_stop(1'b0);

      // R10: pause inside the address with toggling clock and data
      cs_start(1'b0);
      xbyte(8'h99, o, oe);
      xbyte(8'h00, o, oe);
      xbyte(8'h00, o, oe);
      bitx(1'b0, ob, oe); bitx(1'b0, ob, oe); bitx(1'b1, ob, oe); bitx(1'b0, ob, oe);
      sck = 1'b0; tick(HP);
      hold_n = 1'b0; tick(HP);
      for (int i = 0; i < 4; i++) begin
         si = 1'b1; sck = 1'b1; tick(HP);
         sck = 1'b0; tick(HP);
      end
      hold_n = 1'b1; tick(HP);
      bitx(1'b0, ob, oe); bitx(1'b0, ob, oe); bitx(1'b0, ob, oe); bitx(1'b0, ob, oe);
      exp_wr.push_back({24'h000020, 8'hF0}); exp_wr_tag.push_back("R10");
      xbyte(8'hF0, o, oe);
      cs_stop(1'b0);
      rd_idx = 8'h20; tick(1);
      check("R10 address kept across hold", {24'd0, rd_data}, 32'hF0);

      tick(20);
      check("R5 all expected writes seen", exp_wr.size(), 32'd0);
      check("R3 all expected reads seen", exp_rd.size(), 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule